// File: doc/BRIEF.md
# Bidirectional Start-Pulse Load Sequencer

This block fills one display line, made of a parameterised number of three-channel stages, from an 18-bit pixel bus. Each stage holds three 6-bit colour channels. A start pulse arms the block, and it then writes one incoming pixel per clock into successive stages. After the last stage is written it stops on its own and waits for the next start pulse. A direction input decides two things together: which of the two start-pulse pins is the input, and whether stages fill from the low end or the high end of the line.

Several devices can be chained to build a wider line. The pin that is not the start input becomes a carry output. It pulses while the final stage is being written, so the next device in the chain picks up the very next pixel. Both pins are modelled as input, output and output-enable triplets. Only the carry pin is ever enabled.

A separate line-clear input acts on its rising edge. It empties the stage-position register, which ends any load in progress. The stored pixels are left as they are.

Top module: `spl_load_seq`

## Requirements
- R1: While reset is asserted, every stage of the line register reads zero and both carry outputs are low.
- R2: With `dir_fwd` high, pin A is the start input, `sp_b_oe` is high and `sp_a_oe` is low. With `dir_fwd` low the roles swap. The two enables are never high together. A pulse on the pin that currently has the output role starts nothing.
- R3: A start pulse sampled high on a clock edge loads nothing on that edge. The pixel presented on the following edge is the first pixel written.
- R4: With `dir_fwd` high, the k-th pixel after the start (k counted from 0) is written to stage k. Stage s occupies bits [s*18 +: 18] of `line_q`, and each 18-bit pixel word is stored unchanged.
- R5: With `dir_fwd` low, the k-th pixel after the start is written to stage STAGES-1-k.
- R6: After STAGES pixels have been written, the block is in standby. Further clocks change no stage until a new start pulse arrives.
- R7: The carry output (`sp_b_out` when `dir_fwd` is high, `sp_a_out` when it is low) is high for exactly the one clock period that ends with the edge writing the final stage. It is low at all other times.
- R8: A start pulse held high for two clock periods is counted once. Loading begins on the edge after its rising edge, so the pixel presented during its second period is the first pixel written.
- R9: A start pulse that rises during a load restarts the sequence from the first stage. The edge that samples it writes nothing.
- R10: A rising edge of `line_clr` puts the block into standby, and that edge writes nothing. A level held high, or a rising edge during standby, has no further effect. Stored pixels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Load clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | Shift direction: 1 = pin A input, fill upward; 0 = pin B input, fill downward |
| line_clr | input | 1 | Line clear; its rising edge empties the position register |
| pix_in | input | 18 | Pixel word, three 6-bit channels |
| sp_a_in | input | 1 | Start pin A, receive side |
| sp_a_out | output | 1 | Start pin A, drive side (carry when dir_fwd is low) |
| sp_a_oe | output | 1 | Start pin A output enable |
| sp_b_in | input | 1 | Start pin B, receive side |
| sp_b_out | output | 1 | Start pin B, drive side (carry when dir_fwd is high) |
| sp_b_oe | output | 1 | Start pin B output enable |
| line_q | output | STAGES*18 | Line register, stage s at bits [s*18 +: 18] |

## Verification
Complete lines are written in both directions, and every line carries a distinct pixel value per position computed from a base number. A pixel that lands in the wrong stage therefore shows up as a mismatch, so an off-by-one in the start latency, a reversed fill order and a missed standby can each be told apart. Two-period start pulses separate edge detection from level detection. A start pulse that arrives partway through a line shows whether the sequence restarts and whether the restart edge wrongly writes a pixel. Pulses on the output-role pin, and line-clear edges in the middle of a line and during standby, show that neither one starts a load.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int unsigned CH_BITS   = 6;
  localparam int unsigned CH_COUNT  = 3;
  localparam int unsigned PIX_BITS  = CH_BITS * CH_COUNT;

  typedef logic [PIX_BITS-1:0] pix_t;

  // Logical load order -> physical stage index
  function automatic int unsigned phys_stage(input int unsigned pos,
                                             input int unsigned n,
                                             input logic fwd);
    return fwd ? pos : (n - 1 - pos);
  endfunction

endpackage

// File: rtl/spl_rise_det.sv
module spl_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/spl_pos_ring.sv
module spl_pos_ring #(
  parameter int unsigned STAGES = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rise,
  input  logic              clr_rise,
  output logic [STAGES-1:0] wr_log,
  output logic              last_pos
);

  logic [STAGES-1:0] tok_q;
  logic [STAGES-1:0] tok_n;
  logic              tok_en;
  logic              busy;
  logic              load_ok;

  assign busy    = |tok_q;
  assign load_ok = busy & ~start_rise & ~clr_rise;
  assign tok_en  = clr_rise | start_rise | busy;

  always_comb begin
    tok_n = tok_q;
    if (clr_rise)        tok_n = '0;
    else if (start_rise) tok_n = STAGES'(1);
    else if (busy)       tok_n = tok_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tok_q <= '0;
    else if (tok_en) tok_q <= tok_n;
  end

  assign wr_log   = tok_q & {STAGES{load_ok}};
  assign last_pos = tok_q[STAGES-1];

  p_tok_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));

  p_restart_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !clr_rise) |=> (tok_q == STAGES'(1)));

  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> (tok_q == '0));

  p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q == '0 && !start_rise) |=> (tok_q == '0));

endmodule

// File: rtl/spl_line_store.sv
module spl_line_store
  import spl_pkg::*;
#(
  parameter int unsigned STAGES = 140
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fwd,
  input  logic [STAGES-1:0]          wr_log,
  input  pix_t                       pix,
  output logic [STAGES*PIX_BITS-1:0] line_q
);

  logic [STAGES-1:0] wr_phys;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned S_REV = phys_stage(s, STAGES, 1'b0);
    pix_t stage_q;

    assign wr_phys[s] = fwd ? wr_log[s] : wr_log[S_REV];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stage_q <= '0;
      else if (wr_phys[s]) stage_q <= pix;
    end

    assign line_q[s*PIX_BITS +: PIX_BITS] = stage_q;
  end

  p_wr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_phys));

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_log == '0) |=> $stable(line_q));

endmodule

// File: rtl/spl_load_seq.sv
module spl_load_seq
  import spl_pkg::*;
#(
  parameter int unsigned STAGES = 140
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dir_fwd,
  input  logic                       line_clr,
  input  logic [PIX_BITS-1:0]        pix_in,
  input  logic                       sp_a_in,
  output logic                       sp_a_out,
  output logic                       sp_a_oe,
  input  logic                       sp_b_in,
  output logic                       sp_b_out,
  output logic                       sp_b_oe,
  output logic [STAGES*PIX_BITS-1:0] line_q
);

  logic              start_lvl;
  logic              start_rise;
  logic              clr_rise;
  logic [STAGES-1:0] wr_log;
  logic              carry;

  assign start_lvl = dir_fwd ? sp_a_in : sp_b_in;

  spl_rise_det u_start_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (start_lvl),
    .rise  (start_rise)
  );

  spl_rise_det u_clr_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (line_clr),
    .rise  (clr_rise)
  );

  spl_pos_ring #(.STAGES(STAGES)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rise (start_rise),
    .clr_rise   (clr_rise),
    .wr_log     (wr_log),
    .last_pos   (carry)
  );

  spl_line_store #(.STAGES(STAGES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .fwd    (dir_fwd),
    .wr_log (wr_log),
    .pix    (pix_in),
    .line_q (line_q)
  );

  assign sp_a_oe  = ~dir_fwd;
  assign sp_b_oe  =  dir_fwd;
  assign sp_a_out = ~dir_fwd & carry;
  assign sp_b_out =  dir_fwd & carry;

  p_pins_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sp_a_oe, sp_b_oe}));

  if (STAGES > 1) begin : g_carry_chk
    p_carry_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_a_out || sp_b_out) |=> !(sp_a_out || sp_b_out));
  end

endmodule

// File: tb/spl_load_seq_test.sv
module spl_load_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int PW = 18;

  logic clk = 1'b0;
  logic rst_n, dir_fwd, line_clr, sp_a_in, sp_b_in;
  logic [PW-1:0] pix_in;
  logic sp_a_out, sp_a_oe, sp_b_out, sp_b_oe;
  logic [N*PW-1:0] line_q;

  int checks = 0;
  int errors = 0;
  logic [PW-1:0] exp_stage [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  spl_load_seq #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .line_clr(line_clr),
    .pix_in(pix_in), .sp_a_in(sp_a_in), .sp_a_out(sp_a_out), .sp_a_oe(sp_a_oe),
    .sp_b_in(sp_b_in), .sp_b_out(sp_b_out), .sp_b_oe(sp_b_oe), .line_q(line_q)
  );

  function automatic logic [PW-1:0] pv(input int b, input int i);
    return PW'((b * 7919 + i * 613 + 17) % 262144);
  endfunction

  function automatic int phys(input logic fwd, input int p);
    return fwd ? p : N - 1 - p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < N; s++)
      chk(line_q[s*PW +: PW] == exp_stage[s], tag, line_q[s*PW +: PW], exp_stage[s]);
  endtask

  function automatic logic carry_pin(input logic fwd);
    return fwd ? sp_b_out : sp_a_out;
  endfunction

  task automatic set_start(input logic fwd, input logic v);
    if (fwd) sp_a_in = v; else sp_b_in = v;
  endtask

  // Called at a negedge one edge after the start was sampled.
  task automatic feed_line(input logic fwd, input int base, input int w);
    for (int i = 0; i < N; i++) begin
      if (w == 1 || i > 0) set_start(fwd, 1'b0);
      pix_in = pv(base, i);
      chk(carry_pin(fwd) == (i == N - 1), "R7 carry", carry_pin(fwd), (i == N - 1));
      exp_stage[phys(fwd, i)] = pv(base, i);
      @(negedge clk);
    end
    chk(carry_pin(fwd) == 1'b0, "R7 carry low after line", carry_pin(fwd), 0);
  endtask

  task automatic run_line(input logic fwd, input int base, input int w);
    dir_fwd = fwd;
    set_start(fwd, 1'b1);
    pix_in = '1;
    @(negedge clk);
    feed_line(fwd, base, w);
  endtask

  task automatic idle_pixels(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      pix_in = pv(base, i);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_fwd = 1'b1; line_clr = 1'b0;
    sp_a_in = 1'b0; sp_b_in = 1'b0; pix_in = '0;
    for (int s = 0; s < N; s++) exp_stage[s] = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset line");
    chk(!sp_a_out && !sp_b_out, "R1 carry in reset", {sp_a_out, sp_b_out}, 0);
    chk(sp_b_oe && !sp_a_oe, "R2 fwd enables", {sp_a_oe, sp_b_oe}, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: forward fill, one-period start
    run_line(1'b1, 1, 1);
    check_all("R3 R4 forward fill");
    // R6: standby
    idle_pixels(4, 90);
    check_all("R6 standby");
    // R8: two-period start
    run_line(1'b1, 2, 2);
    check_all("R8 wide start");

    // R5: reverse fill
    dir_fwd = 1'b0;
    @(negedge clk);
    chk(sp_a_oe && !sp_b_oe, "R2 rev enables", {sp_a_oe, sp_b_oe}, 2);
    run_line(1'b0, 3, 1);
    check_all("R5 reverse fill");
    run_line(1'b0, 4, 2);
    check_all("R5 R8 reverse wide start");

    // R2: pulse on output-role pin ignored
    sp_a_in = 1'b1; pix_in = '1;
    @(negedge clk);
    sp_a_in = 1'b0;
    idle_pixels(N + 2, 91);
    check_all("R2 output pin ignored");
    dir_fwd = 1'b1;
    sp_b_in = 1'b1;
    @(negedge clk);
    sp_b_in = 1'b0;
    idle_pixels(N + 2, 92);
    check_all("R2 output pin ignored fwd");

    // R9: restart mid-line
    run_line(1'b1, 20, 1);
    sp_a_in = 1'b1; pix_in = '1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sp_a_in = 1'b0;
      pix_in = pv(21, i);
      exp_stage[phys(1'b1, i)] = pv(21, i);
      @(negedge clk);
    end
    sp_a_in = 1'b1; pix_in = '1;
    @(negedge clk);
    chk(line_q[3*PW +: PW] == exp_stage[3], "R9 restart edge writes nothing",
        line_q[3*PW +: PW], exp_stage[3]);
    check_all("R9 partial line");
    feed_line(1'b1, 22, 1);
    check_all("R9 restarted line");

    // R10: line clear mid-line, held, and during standby
    dir_fwd = 1'b0;
    sp_b_in = 1'b1; pix_in = '1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      sp_b_in = 1'b0;
      pix_in = pv(30, i);
      exp_stage[phys(1'b0, i)] = pv(30, i);
      @(negedge clk);
    end
    line_clr = 1'b1;
    idle_pixels(4, 31);
    chk(sp_a_out == 1'b0, "R10 carry after clear", sp_a_out, 0);
    line_clr = 1'b0;
    idle_pixels(2, 32);
    line_clr = 1'b1;
    idle_pixels(N + 1, 33);
    line_clr = 1'b0;
    check_all("R10 clear stops load");
    run_line(1'b0, 34, 1);
    check_all("R10 load after clear");

    // Sweep: many lines in both directions and start widths
    for (int b = 40; b < 56; b++) begin
      run_line(b[0], b, (b % 4 < 2) ? 1 : 2);
      check_all(b[0] ? "R4 sweep" : "R5 sweep");
      idle_pixels(2, b + 100);
      check_all("R6 sweep standby");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule